// File: doc/BRIEF.md
# Speculative Load Address Check Table

This block keeps track of loads that a compiler has hoisted above stores that might write the same memory location. When such an early load issues, it records its destination register tag and its address in a small table. From then on, every store address is compared against all of the live entries at once. Any entry whose address falls in the same 8-byte granule as the store is killed.

Later, at the load's original position in the program, a check names the register tag. The table answers on a response port. The answer is "ok" when the entry is still live. It is "fixup" when the entry was killed or was never written, and fixup tells the pipeline to run recovery code.

The table holds one slot per register tag. A flush input drops every entry at once, for example on a context switch.

Top module: `ldspec_guard`

## Requirements
- R1: After reset every entry is invalid, so a check of any tag 0 to 15 reports fixup.
- R2: An insert writes the slot chosen by `ins_tag_i` (binary index 0 to 15) and marks it valid. A check of that tag in any later cycle reports ok, provided no store or flush has removed the entry in between.
- R3: A check in cycle t produces a response in cycle t+1. In that cycle `chk_rsp_vld_o` is high and exactly one of `chk_ok_o` and `chk_fixup_o` is high. In a cycle that follows no check, all three outputs are low.
- R4: A valid store invalidates every valid entry whose address bits [31:3] equal the store's bits [31:3]. Bits [2:0] are ignored. An entry that differs in any bit from 3 up to the top bit stays valid.
- R5: A check sees the table as it stood at the start of its own cycle. An insert, store or flush in the same cycle does not change that check's answer.
- R6: A check never modifies the table. A tag that checked ok still checks ok, and a tag that failed still fails.
- R7: An insert to a tag that is already valid replaces the stored address. Stores are then compared against the new address only.
- R8: When an insert and a matching store occur in the same cycle, the store compare happens first. The inserted entry ends the cycle valid.
- R9: A flush clears all valid bits, and it also wins over an insert in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| flush_i | input | 1 | Drop all entries |
| ins_vld_i | input | 1 | Advanced load insert strobe |
| ins_tag_i | input | 4 | Destination register tag of the inserted load |
| ins_addr_i | input | 32 | Address of the inserted load |
| st_vld_i | input | 1 | Store snoop strobe |
| st_addr_i | input | 32 | Store address |
| chk_vld_i | input | 1 | Check request strobe |
| chk_tag_i | input | 4 | Register tag being checked |
| chk_rsp_vld_o | output | 1 | Check response valid, one cycle after the request |
| chk_ok_o | output | 1 | Entry still valid: the speculative load result may be used |
| chk_fixup_o | output | 1 | Entry invalid or missing: recovery is required |

## Verification
The bench targets the following corner cases, each with the failure it would expose:
- **Address granularity.** A store in the same granule but at a different byte offset must kill the entry. A store whose only difference is the top address bit must not. A comparator of the wrong width either misses real conflicts or kills safe loads.
- **Same-granule entries.** Two tags that share one granule must both die on a single store. A priority-style match would kill only the first of them.
- **Same-cycle ordering, store and insert.** When an insert and a matching store land together, the new entry must survive. A design that compares after writing would report a spurious fixup.
- **Same-cycle ordering, flush and insert.** A flush must beat an insert in the same cycle. The opposite priority would leave a stale entry live.
- **Check timing and persistence.** A check must read the pre-update state, and a failed check must stay failed. A design that checked post-update state, or re-validated on a check, would return ok where recovery is needed.

// File: rtl/ldspec_pkg.sv
package ldspec_pkg;

  // Registered answer to one check request.
  typedef struct packed {
    logic vld;
    logic ok;
    logic fixup;
  } chk_rsp_t;

  localparam chk_rsp_t RSP_IDLE = '{vld: 1'b0, ok: 1'b0, fixup: 1'b0};

  // Build the answer for one cycle from the request strobe and the lookup hit.
  function automatic chk_rsp_t make_rsp(input logic req, input logic hit);
    chk_rsp_t r;
    r.vld   = req;
    r.ok    = req & hit;
    r.fixup = req & ~hit;
    return r;
  endfunction

endpackage

// File: rtl/ldspec_rst_sync.sv
// Asynchronous assert, synchronous release reset conditioner.
module ldspec_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/ldspec_entry.sv
// One table slot: valid bit plus stored address granule, with its own snoop comparator.
module ldspec_entry #(
  parameter int unsigned KEY_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             ins_sel_i,
  input  logic [KEY_W-1:0] ins_key_i,
  input  logic             st_vld_i,
  input  logic [KEY_W-1:0] st_key_i,
  output logic             valid_o
);

  logic             valid_q;
  logic             valid_d;
  logic [KEY_W-1:0] key_q;
  logic             key_en;
  logic             snoop_hit;

  // The comparator runs against the held key, before any write this cycle.
  always_comb begin
    snoop_hit = st_vld_i && valid_q && (st_key_i == key_q);
  end

  // Priority, lowest first: hold, store kill, insert, flush.
  always_comb begin
    valid_d = valid_q;
    if (snoop_hit) begin
      valid_d = 1'b0;
    end
    if (ins_sel_i) begin
      valid_d = 1'b1;
    end
    if (flush_i) begin
      valid_d = 1'b0;
    end
    key_en = ins_sel_i && !flush_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  // Address storage needs no reset: it is qualified by the valid bit.
  always_ff @(posedge clk) begin
    if (key_en) begin
      key_q <= ins_key_i;
    end
  end

  assign valid_o = valid_q;

endmodule

// File: rtl/ldspec_lookup.sv
// Selects the valid bit of the slot named by a check.
module ldspec_lookup #(
  parameter int unsigned TAG_W   = 4,
  parameter int unsigned ENTRIES = 16
) (
  input  logic [ENTRIES-1:0] valid_vec_i,
  input  logic [TAG_W-1:0]   chk_tag_i,
  output logic               hit_o
);

  always_comb begin
    hit_o = 1'b0;
    for (int k = 0; k < ENTRIES; k++) begin
      if (chk_tag_i == TAG_W'(k)) begin
        hit_o = valid_vec_i[k];
      end
    end
  end

endmodule

// File: rtl/ldspec_guard.sv
module ldspec_guard
  import ldspec_pkg::*;
#(
  parameter int unsigned TAG_W       = 4,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned GRAIN_LSB   = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              ins_vld_i,
  input  logic [TAG_W-1:0]  ins_tag_i,
  input  logic [ADDR_W-1:0] ins_addr_i,
  input  logic              st_vld_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic              chk_vld_i,
  input  logic [TAG_W-1:0]  chk_tag_i,
  output logic              chk_rsp_vld_o,
  output logic              chk_ok_o,
  output logic              chk_fixup_o
);

  localparam int unsigned ENTRIES = 1 << TAG_W;
  localparam int unsigned KEY_W   = ADDR_W - GRAIN_LSB;

  logic               rst_sync_n;
  logic [KEY_W-1:0]   ins_key;
  logic [KEY_W-1:0]   st_key;
  logic [ENTRIES-1:0] ins_sel;
  logic [ENTRIES-1:0] valid_vec;
  logic               chk_hit;
  chk_rsp_t           rsp_q;
  chk_rsp_t           rsp_d;
  logic               unused_low_bits;

  ldspec_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign ins_key         = ins_addr_i[ADDR_W-1:GRAIN_LSB];
  assign st_key          = st_addr_i[ADDR_W-1:GRAIN_LSB];
  assign unused_low_bits = ^{ins_addr_i[GRAIN_LSB-1:0], st_addr_i[GRAIN_LSB-1:0]};

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign ins_sel[g] = ins_vld_i && (ins_tag_i == TAG_W'(g));

    ldspec_entry #(.KEY_W(KEY_W)) u_entry (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .flush_i   (flush_i),
      .ins_sel_i (ins_sel[g]),
      .ins_key_i (ins_key),
      .st_vld_i  (st_vld_i),
      .st_key_i  (st_key),
      .valid_o   (valid_vec[g])
    );
  end

  ldspec_lookup #(.TAG_W(TAG_W), .ENTRIES(ENTRIES)) u_lookup (
    .valid_vec_i (valid_vec),
    .chk_tag_i   (chk_tag_i),
    .hit_o       (chk_hit)
  );

  always_comb begin
    rsp_d = make_rsp(chk_vld_i, chk_hit);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_q <= RSP_IDLE;
    end else begin
      rsp_q <= rsp_d;
    end
  end

  assign chk_rsp_vld_o = rsp_q.vld;
  assign chk_ok_o      = rsp_q.ok;
  assign chk_fixup_o   = rsp_q.fixup;

endmodule

// File: rtl/ldspec_guard_chk.sv
module ldspec_guard_chk #(
  parameter int unsigned TAG_W = 4
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             flush_i,
  input logic             ins_vld_i,
  input logic [TAG_W-1:0] ins_tag_i,
  input logic             chk_vld_i,
  input logic [TAG_W-1:0] chk_tag_i,
  input logic             chk_rsp_vld_o,
  input logic             chk_ok_o,
  input logic             chk_fixup_o
);

  // Set one cycle after reset release so $past never reaches into reset.
  logic armed_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
    end
  end

  // R3
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    chk_vld_i |=> chk_rsp_vld_o);

  // R3
  no_rsp_without_req_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !chk_vld_i |=> (!chk_rsp_vld_o && !chk_ok_o && !chk_fixup_o));

  // R3
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    chk_rsp_vld_o |-> $countones({chk_ok_o, chk_fixup_o}) == 1);

  // R2
  insert_then_ok_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (armed_q && $past(ins_vld_i) && !$past(flush_i) && chk_vld_i
      && chk_tag_i == $past(ins_tag_i)) |=> chk_ok_o);

  // R9
  flush_then_fixup_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (armed_q && $past(flush_i) && chk_vld_i) |=> chk_fixup_o);

endmodule

bind ldspec_guard ldspec_guard_chk #(.TAG_W(TAG_W)) u_guard_chk (
  .clk           (clk),
  .rst_sync_n    (rst_sync_n),
  .flush_i       (flush_i),
  .ins_vld_i     (ins_vld_i),
  .ins_tag_i     (ins_tag_i),
  .chk_vld_i     (chk_vld_i),
  .chk_tag_i     (chk_tag_i),
  .chk_rsp_vld_o (chk_rsp_vld_o),
  .chk_ok_o      (chk_ok_o),
  .chk_fixup_o   (chk_fixup_o)
);

// File: tb/ldspec_guard_test.sv
module ldspec_guard_test;

  typedef struct packed {
    logic        fl;
    logic        iv;
    logic [3:0]  it;
    logic [31:0] ia;
    logic        sv;
    logic [31:0] sa;
    logic        cv;
    logic [3:0]  ct;
    logic        er;
    logic        eo;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,4'd0, 32'h0,        1'b0,32'h0,        1'b1,4'd3, 1'b1,1'b0},
    '{1'b0,1'b1,4'd3, 32'h1000,     1'b0,32'h0,        1'b0,4'd0, 1'b0,1'b0},
    '{1'b0,1'b0,4'd0, 32'h0,        1'b0,32'h0,        1'b1,4'd3, 1'b1,1'b1},
    '{1'b0,1'b0,4'd0, 32'h0,        1'b1,32'h1004,     1'b1,4'd3, 1'b1,1'b1},
    '{1'b0,1'b0,4'd0, 32'h0,        1'b0,32'h0,        1'b1,4'd3, 1'b1,1'b0},
    '{1'b0,1'b0,4'd0, 32'h0,        1'b0,32'h0,        1'b1,4'd3, 1'b1,1'b0},
    '{1'b0,1'b1,4'd5, 32'h2000,     1'b0,32'h0,        1'b0,4'd0, 1'b0,1'b0},
    '{1'b0,1'b1,4'd6, 32'h2000,     1'b0,32'h0,        1'b0,4'd0, 1'b0,1'b0},
    '{1'b0,1'b1,4'd7, 32'h2008,     1'b0,32'h0,        1'b0,4'd0, 1'b0,1'b0},
    '{1'b0,1'b0,4'd0, 32'h0,        1'b1,32'h2007,     1'b1,4'd5, 1'b1,1'b1},
    '{1'b0,1'b0,4'd0, 32'h0,        1'b0,32'h0,        1'b1,4'd6, 1'b1,1'b0},
    '{1'b0,1'b0,4'd0, 32'h0,        1'b0,32'h0,        1'b1,4'd7, 1'b1,1'b1},
    '{1'b0,1'b0,4'd0, 32'h0,        1'b0,32'h0,        1'b1,4'd7, 1'b1,1'b1},
    '{1'b0,1'b1,4'd7, 32'h3000,     1'b0,32'h0,        1'b0,4'd0, 1'b0,1'b0},
    '{1'b0,1'b0,4'd0, 32'h0,        1'b1,32'h2008,     1'b0,4'd0, 1'b0,1'b0},
    '{1'b0,1'b0,4'd0, 32'h0,        1'b0,32'h0,        1'b1,4'd7, 1'b1,1'b1},
    '{1'b0,1'b1,4'd9, 32'h4000,     1'b1,32'h4000,     1'b0,4'd0, 1'b0,1'b0},
    '{1'b0,1'b0,4'd0, 32'h0,        1'b0,32'h0,        1'b1,4'd9, 1'b1,1'b1},
    '{1'b1,1'b1,4'd10,32'h5000,     1'b0,32'h0,        1'b0,4'd0, 1'b0,1'b0},
    '{1'b0,1'b0,4'd0, 32'h0,        1'b0,32'h0,        1'b1,4'd10,1'b1,1'b0},
    '{1'b0,1'b0,4'd0, 32'h0,        1'b0,32'h0,        1'b1,4'd7, 1'b1,1'b0},
    '{1'b0,1'b1,4'd15,32'hFFFF_FFF8,1'b0,32'h0,        1'b0,4'd0, 1'b0,1'b0},
    '{1'b0,1'b0,4'd0, 32'h0,        1'b1,32'h7FFF_FFF8,1'b0,4'd0, 1'b0,1'b0},
    '{1'b0,1'b0,4'd0, 32'h0,        1'b0,32'h0,        1'b1,4'd15,1'b1,1'b1}
  };

  function automatic string vreq(input int i);
    case (i)
      0:       return "R1";
      1:       return "R3";
      2:       return "R2";
      3, 9:    return "R5";
      4, 10:   return "R4";
      11, 23:  return "R4";
      5, 12:   return "R6";
      15:      return "R7";
      17:      return "R8";
      19, 20:  return "R9";
      default: return "R3";
    endcase
  endfunction

  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush_i;
  logic        ins_vld_i;
  logic [3:0]  ins_tag_i;
  logic [31:0] ins_addr_i;
  logic        st_vld_i;
  logic [31:0] st_addr_i;
  logic        chk_vld_i;
  logic [3:0]  chk_tag_i;
  logic        chk_rsp_vld_o;
  logic        chk_ok_o;
  logic        chk_fixup_o;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  always #4 clk = ~clk;

  ldspec_guard uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush_i       (flush_i),
    .ins_vld_i     (ins_vld_i),
    .ins_tag_i     (ins_tag_i),
    .ins_addr_i    (ins_addr_i),
    .st_vld_i      (st_vld_i),
    .st_addr_i     (st_addr_i),
    .chk_vld_i     (chk_vld_i),
    .chk_tag_i     (chk_tag_i),
    .chk_rsp_vld_o (chk_rsp_vld_o),
    .chk_ok_o      (chk_ok_o),
    .chk_fixup_o   (chk_fixup_o)
  );

  task automatic expect_rsp(input string req, input logic er, input logic eo);
    logic ef;
    ef = er & ~eo;
    n_checks++;
    if (chk_rsp_vld_o !== er || chk_ok_o !== eo || chk_fixup_o !== ef) begin
      n_fail++;
      $display("FAIL %s: got vld/ok/fixup=%b%b%b expected %b%b%b", req,
               chk_rsp_vld_o, chk_ok_o, chk_fixup_o, er, eo, ef);
    end
  endtask

  task automatic idle_inputs();
    flush_i = 1'b0; ins_vld_i = 1'b0; ins_tag_i = '0; ins_addr_i = '0;
    st_vld_i = 1'b0; st_addr_i = '0; chk_vld_i = 1'b0; chk_tag_i = '0;
  endtask

  // Drive one cycle of stimulus at a falling edge; sample at the next falling edge.
  task automatic step(input vec_t v, input string req);
    flush_i = v.fl; ins_vld_i = v.iv; ins_tag_i = v.it; ins_addr_i = v.ia;
    st_vld_i = v.sv; st_addr_i = v.sa; chk_vld_i = v.cv; chk_tag_i = v.ct;
    @(negedge clk);
    idle_inputs();
    expect_rsp(req, v.er, v.eo);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    idle_inputs();
    do_reset();

    // R1: outputs idle after reset
    expect_rsp("R1", 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i], vreq(i));
    end

    // R1: a live entry is gone after a reset in mid-run
    step('{1'b0,1'b1,4'd2,32'h10,1'b0,32'h0,1'b0,4'd0,1'b0,1'b0}, "R2");
    step('{1'b0,1'b0,4'd0,32'h0, 1'b0,32'h0,1'b1,4'd2,1'b1,1'b1}, "R2");
    do_reset();
    for (int t = 0; t < 16; t++) begin
      step('{1'b0,1'b0,4'd0,32'h0,1'b0,32'h0,1'b1,4'(t),1'b1,1'b0}, "R1");
    end

    // R4: disabled store strobe with a matching address leaves the entry alone
    step('{1'b0,1'b1,4'd4,32'h80,1'b0,32'h0,1'b0,4'd0,1'b0,1'b0}, "R2");
    step('{1'b0,1'b0,4'd0,32'h0, 1'b0,32'h80,1'b0,4'd0,1'b0,1'b0}, "R4");
    step('{1'b0,1'b0,4'd0,32'h0, 1'b0,32'h0,1'b1,4'd4,1'b1,1'b1}, "R4");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule